// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 32 on-chip peripheral sources and drives a single interrupt line towards the host CPU. Each source can be enabled or disabled through a mask register. When at least one enabled, requesting source outranks everything that is already in service, and the global enable is on, the line is raised. The CPU finds out which source to serve by writing an acknowledge bit and then reading back a vector number. It ends each service by writing a one to that source's bit in the in-service register.

Sources are ranked by number: a higher number beats a lower one. Software can also promote one chosen source above all the others. Vector 0 is reserved as the error vector. It is returned when an acknowledge arrives but nothing is deliverable any more, for example because the request was withdrawn or masked after the CPU saw the line go up. Request input 0 is therefore unused. The configuration register also holds a 3-bit CPU interrupt level, which goes straight out to the interrupt routing of the core.

The acknowledge sequencer is a three-state machine. ST_QUIET means nothing is deliverable, and the line is low. ST_RAISED means a deliverable source exists, and the line is high. ST_HOLD is the cycle after an acknowledge, and the line is low. The transitions are as follows. Any state goes to ST_HOLD on an acknowledge. ST_QUIET goes to ST_RAISED when a source becomes deliverable. ST_RAISED goes to ST_QUIET when the deliverable source goes away (withdraw, mask or disable). ST_HOLD goes to ST_RAISED or to ST_QUIET according to the deliverable state, which now uses the updated in-service set.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset the configuration, mask, in-service and vector registers all read 0, and irq_out is low.
- R2: The mask register (address 1) reads back what was written. A source is pending only when its request input and its mask bit are both 1. A masked source never raises irq_out.
- R3: Configuration bit 0 is the global enable. While it is 0, irq_out stays low whatever the requests are.
- R4: With no promotion, the pending source with the highest number wins the acknowledge.
- R5: When configuration bit 7 is 1, the source whose index is in configuration bits 12:8 outranks every other source. Configuration reads return only bits 15:7 and bit 0; all other bits read as 0.
- R6: A write to address 3 with data bit 0 = 1 is an acknowledge. It captures the winning source number. A read of address 3 then returns that number in bits 15:11, with all other bits 0. The acknowledge sets the winner's in-service bit (address 2), and irq_out is low in the cycle after it.
- R7: A pending source is presented only if it outranks every source whose in-service bit is set. A higher-ranked source still interrupts while a lower one is in service.
- R8: Writing address 2 clears each in-service bit whose data bit is 1. Bits written with 0 are unchanged.
- R9: A source whose request is still asserted after its in-service bit is cleared raises irq_out again.
- R10: An acknowledge when nothing is deliverable captures vector 0 and leaves the in-service register unchanged. This covers a request masked or withdrawn between irq_out rising and the acknowledge.
- R11: irq_out follows the deliverable condition with one cycle of latency.
- R12: The cpu_level output equals configuration bits 15:13.
- R13: Request input 0 never raises irq_out, because vector 0 is the error vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Level-sensitive request per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register (combinational) |
| irq_out | output | 1 | Interrupt request to the CPU |
| cpu_level | output | 3 | CPU interrupt level from the configuration |

## Verification
A wrong in-service bit shows up at the ports within one cycle. Either irq_out stays low for a source that should nest above the current service, or it rises for one that should be blocked. A wrong winner shows up in the vector read right after the acknowledge. A broken race path returns a real vector number where 0 is expected, or sets an in-service bit that the next readback exposes. Because irq_out is registered, a sequencer stuck in one state is seen at the first idle cycle after the stimulus.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_RAISED = 2'd1,
        ST_HOLD   = 2'd2
    } seq_state_t;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_ISR  = 2'd2;
    localparam logic [1:0] ADDR_VEC  = 2'd3;

    localparam int CFG_GIE_BIT   = 0;
    localparam int CFG_OVR_BIT   = 7;
    localparam int CFG_OSRC_LSB  = 8;
    localparam int CFG_LVL_LSB   = 13;
    localparam int LVL_W         = 3;
    localparam int VEC_LSB       = 11;
    localparam int ACK_BIT       = 0;
endpackage

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
    import vpic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int VW   = $clog2(NSRC),
    parameter int RW   = $clog2(NSRC + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] isr,
    input  logic            gie,
    input  logic            ovr_en,
    input  logic [VW-1:0]   ovr_src,
    output logic            deliver,
    output logic [VW-1:0]   win_idx
);
    localparam logic [RW-1:0] PROMO_RANK = RW'(NSRC + 1);

    logic [NSRC-1:0] pend;
    logic [RW-1:0]   rank [NSRC];
    logic [RW-1:0]   best_pend;
    logic [RW-1:0]   best_isr;

    // bit 0 is the error vector slot and never pends
    assign pend = req & mask & ~NSRC'(1);

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_rank
            assign rank[g] = (ovr_en && (ovr_src == VW'(g))) ? PROMO_RANK : RW'(g + 1);
        end
    endgenerate

    always_comb begin
        best_pend = '0;
        best_isr  = '0;
        win_idx   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (rank[i] > best_pend)) begin
                best_pend = rank[i];
                win_idx   = VW'(i);
            end
            if (isr[i] && (rank[i] > best_isr)) begin
                best_isr = rank[i];
            end
        end
    end

    assign deliver = gie && (best_pend > best_isr);

    assert_win_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |-> (req[win_idx] && mask[win_idx]));

    assert_win_not_serviced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |-> !isr[win_idx]);
endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int VW   = $clog2(NSRC),
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    input  logic            win_ok,
    input  logic [VW-1:0]   win_idx,
    output logic            ack_fire,
    output logic            gie,
    output logic            ovr_en,
    output logic [VW-1:0]   ovr_src,
    output logic [LVL_W-1:0] level,
    output logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] isr,
    output logic [DW-1:0]   rdata
);
    logic            gie_q, ovr_q;
    logic [VW-1:0]   osrc_q;
    logic [LVL_W-1:0] lvl_q;
    logic [NSRC-1:0] mask_q, isr_q, isr_set, isr_clr;
    logic [VW-1:0]   vec_q;
    logic            wr_cfg, wr_mask, wr_isr;

    assign wr_cfg   = wr_en && (addr == ADDR_CFG);
    assign wr_mask  = wr_en && (addr == ADDR_MASK);
    assign wr_isr   = wr_en && (addr == ADDR_ISR);
    assign ack_fire = wr_en && (addr == ADDR_VEC) && wdata[ACK_BIT];

    assign isr_set = (ack_fire && win_ok) ? (NSRC'(1) << win_idx) : '0;
    assign isr_clr = wr_isr ? wdata[NSRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q  <= 1'b0;
            ovr_q  <= 1'b0;
            osrc_q <= '0;
            lvl_q  <= '0;
            mask_q <= '0;
            isr_q  <= '0;
            vec_q  <= '0;
        end else begin
            if (wr_cfg) begin
                gie_q  <= wdata[CFG_GIE_BIT];
                ovr_q  <= wdata[CFG_OVR_BIT];
                osrc_q <= wdata[CFG_OSRC_LSB +: VW];
                lvl_q  <= wdata[CFG_LVL_LSB +: LVL_W];
            end
            if (wr_mask) begin
                mask_q <= wdata[NSRC-1:0];
            end
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (ack_fire) begin
                vec_q <= win_ok ? win_idx : '0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CFG: begin
                rdata[CFG_GIE_BIT]              = gie_q;
                rdata[CFG_OVR_BIT]              = ovr_q;
                rdata[CFG_OSRC_LSB +: VW]       = osrc_q;
                rdata[CFG_LVL_LSB +: LVL_W]     = lvl_q;
            end
            ADDR_MASK: rdata[NSRC-1:0] = mask_q;
            ADDR_ISR:  rdata[NSRC-1:0] = isr_q;
            ADDR_VEC:  rdata[VEC_LSB +: VW] = vec_q;
            default:   rdata = '0;
        endcase
    end

    assign gie     = gie_q;
    assign ovr_en  = ovr_q;
    assign ovr_src = osrc_q;
    assign level   = lvl_q;
    assign mask    = mask_q;
    assign isr     = isr_q;

    assert_ack_sets_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && win_ok) |=> (isr_q[$past(win_idx)] && (vec_q == $past(win_idx))));

    assert_error_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !win_ok) |=> ((vec_q == '0) && (isr_q == $past(isr_q))));

    assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_isr |=> ((isr_q & $past(wdata[NSRC-1:0])) == '0));

    assert_eoi_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_isr |=> ((isr_q & ~$past(wdata[NSRC-1:0])) == ($past(isr_q) & ~$past(wdata[NSRC-1:0]))));
endmodule

// File: rtl/vpic_seq.sv
module vpic_seq
    import vpic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic deliver,
    input  logic ack_fire,
    input  logic gie,
    output logic irq_out
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (ack_fire)     state_d = ST_HOLD;
                else if (deliver) state_d = ST_RAISED;
            end
            ST_RAISED: begin
                if (ack_fire)      state_d = ST_HOLD;
                else if (!deliver) state_d = ST_QUIET;
            end
            ST_HOLD: begin
                if (ack_fire)     state_d = ST_HOLD;
                else if (deliver) state_d = ST_RAISED;
                else              state_d = ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq_out = (state_q == ST_RAISED);
    end

    assert_gie_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(gie));

    assert_ack_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> !irq_out);

    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_fire && deliver) |=> irq_out);
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
    import vpic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int DW   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_req,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq_out,
    output logic [LVL_W-1:0] cpu_level
);
    localparam int VW = $clog2(NSRC);
    localparam int RW = $clog2(NSRC + 2);

    logic            ack_fire, gie, ovr_en, deliver;
    logic [VW-1:0]   ovr_src, win_idx;
    logic [NSRC-1:0] mask, isr;

    vpic_regs #(.NSRC(NSRC), .VW(VW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .win_ok   (deliver),
        .win_idx  (win_idx),
        .ack_fire (ack_fire),
        .gie      (gie),
        .ovr_en   (ovr_en),
        .ovr_src  (ovr_src),
        .level    (cpu_level),
        .mask     (mask),
        .isr      (isr),
        .rdata    (rdata)
    );

    vpic_arbiter #(.NSRC(NSRC), .VW(VW), .RW(RW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (src_req),
        .mask    (mask),
        .isr     (isr),
        .gie     (gie),
        .ovr_en  (ovr_en),
        .ovr_src (ovr_src),
        .deliver (deliver),
        .win_idx (win_idx)
    );

    vpic_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .deliver  (deliver),
        .ack_fire (ack_fire),
        .gie      (gie),
        .irq_out  (irq_out)
    );

    assert_src0_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == NSRC'(1)) |=> !deliver || (src_req != NSRC'(1)));
endmodule

// File: tb/test_vpic_ctrl.sv
`timescale 1ns/1ps
module test_vpic_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_req;
    logic        wr_en;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_out;
    logic [2:0]  cpu_level;

    always #2 clk = ~clk;

    vpic_ctrl i_vpic_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out),
        .cpu_level(cpu_level)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_req, m_mask, m_isr;
    logic [15:0] m_cfg;
    logic [4:0]  m_vec;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic int m_rank(int i);
        if (m_cfg[7] && (i == int'(m_cfg[12:8]))) return 33;
        return i + 1;
    endfunction

    // returns winning source, or -1 when nothing is deliverable
    function automatic int m_winner();
        int bp = 0, bi = 0, w = -1;
        for (int i = 0; i < 32; i++) begin
            if (i != 0 && m_req[i] && m_mask[i] && m_rank(i) > bp) begin
                bp = m_rank(i);
                w = i;
            end
            if (m_isr[i] && m_rank(i) > bi) bi = m_rank(i);
        end
        if (!m_cfg[0] || bp <= bi) return -1;
        return w;
    endfunction

    task automatic wr(logic [1:0] a, logic [31:0] d);
        int w;
        case (a)
            2'd0: m_cfg = d[15:0] & 16'hFF81;
            2'd1: m_mask = d;
            2'd2: m_isr = m_isr & ~d;
            default: if (d[0]) begin
                w = m_winner();
                if (w >= 0) begin
                    m_isr[w] = 1'b1;
                    m_vec = 5'(w);
                end else begin
                    m_vec = 5'd0;
                end
            end
        endcase
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic set_req(logic [31:0] r);
        m_req = r;
        src_req = r;
    endtask

    task automatic idle_check(string tag);
        @(negedge clk);
        check(tag, {31'b0, irq_out}, {31'b0, (m_winner() >= 0)});
    endtask

    task automatic ack_check(string tag);
        logic [31:0] v;
        wr(2'd3, 32'h1);
        check({tag, " irq low after ack R6"}, {31'b0, irq_out}, 32'h0);
        rd(2'd3, v);
        check({tag, " vector R6"}, v, {16'h0, m_vec, 11'h0});
        rd(2'd2, v);
        check({tag, " isr R6"}, v, m_isr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1234abcd));
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        m_req = '0; m_mask = '0; m_isr = '0; m_cfg = '0; m_vec = '0;
        src_req = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset reg", v, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq_out}, 32'h0);

        // R2 mask readback and masked source silent
        wr(2'd1, 32'hA5A5_0F0E);
        rd(2'd1, v);
        check("R2 mask readback", v, 32'hA5A5_0F0E);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h1);
        set_req(32'h0000_0100);
        idle_check("R2 masked silent");
        idle_check("R2 masked silent again");

        // R3 global enable off blocks
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0000_0100);
        idle_check("R3 gie off");
        // R11 latency: enable takes one more cycle to show
        wr(2'd0, 32'h1);
        check("R11 not yet", {31'b0, irq_out}, 32'h0);
        idle_check("R11 raised");

        // R4 fixed priority
        wr(2'd1, 32'hFFFF_FFFF);
        set_req(32'h0010_0208);
        idle_check("R4 irq");
        ack_check("R4 highest number");
        check("R4 vec is 20", {27'b0, m_vec}, 32'd20);
        // R7 lower sources blocked while 20 in service
        idle_check("R7 blocked");
        check("R7 blocked low", {31'b0, irq_out}, 32'h0);
        // R7 nesting: higher source breaks through
        set_req(32'h0210_0208);
        idle_check("R7 nest raise");
        check("R7 nest high", {31'b0, irq_out}, 32'h1);
        ack_check("R7 nest");
        check("R7 nest vec 25", {27'b0, m_vec}, 32'd25);
        // R8 write of zeros changes nothing
        wr(2'd2, 32'h0);
        rd(2'd2, v);
        check("R8 zero write keeps", v, 32'h0210_0000);
        wr(2'd2, 32'h0200_0000);
        rd(2'd2, v);
        check("R8 clear 25", v, 32'h0010_0000);
        set_req(32'h0010_0208);
        wr(2'd2, 32'h0010_0000);
        rd(2'd2, v);
        check("R8 clear 20", v, 32'h0);
        // R9 still asserted source requests again
        idle_check("R9 re-request");
        check("R9 irq high", {31'b0, irq_out}, 32'h1);

        // R5 override promotes source 3
        wr(2'd0, 32'hFFFF_0381);
        rd(2'd0, v);
        check("R5 cfg readback", v, 32'h0000_0381);
        idle_check("R5 irq");
        ack_check("R5 override");
        check("R5 vec is 3", {27'b0, m_vec}, 32'd3);
        // promoted source in service blocks everything
        idle_check("R5 promoted blocks");
        check("R5 blocked", {31'b0, irq_out}, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'h1);
        idle_check("R5 back");

        // R10 race: mask removed after irq seen, then ack
        set_req(32'h0000_0020);
        wr(2'd1, 32'h0000_0020);
        idle_check("R10 raised");
        check("R10 pre irq", {31'b0, irq_out}, 32'h1);
        wr(2'd1, 32'h0);
        ack_check("R10 masked race");
        check("R10 vec 0", {27'b0, m_vec}, 32'd0);
        // R10 race: withdraw in the same cycle as ack
        wr(2'd1, 32'h0000_0020);
        idle_check("R10 raised2");
        set_req(32'h0);
        ack_check("R10 withdraw race");
        check("R10 vec 0 again", {27'b0, m_vec}, 32'd0);

        // R13 source 0 never raises
        wr(2'd1, 32'hFFFF_FFFF);
        set_req(32'h1);
        idle_check("R13 src0");
        check("R13 src0 low", {31'b0, irq_out}, 32'h0);

        // R12 level field
        wr(2'd0, 32'h0000_A001);
        check("R12 level", {29'b0, cpu_level}, 32'd5);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: begin set_req($urandom()); idle_check("R4 random req"); end
                1: begin wr(2'd1, $urandom()); idle_check("R2 random mask"); end
                2: begin ack_check("R6 random ack"); idle_check("R7 random after ack"); end
                3: begin wr(2'd2, $urandom()); idle_check("R8 random eoi"); end
                4: begin
                    wr(2'd0, ($urandom() & 32'hFF80) | 32'h1);
                    check("R12 random level", {29'b0, cpu_level}, {29'b0, m_cfg[15:13]});
                    idle_check("R5 random cfg");
                end
                default: begin
                    wr(2'd0, $urandom() & 32'hFF80);
                    idle_check("R3 random gie off");
                    wr(2'd0, m_cfg | 16'h1);
                    idle_check("R3 random gie on");
                end
            endcase
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule